// File: doc/BRIEF.md
# USB Device Transaction Sequencer

This block sequences the two transactions of a minimal full-speed USB device. Its input is a byte-wide stream of already decoded packet bytes. A start marker comes with the first byte of each packet and an end marker with the last byte. A CRC verdict from an upstream checker is valid together with the end marker. The block checks the PID byte itself: the upper nibble must be the one's complement of the lower (type) nibble. It then tracks packet length and decides what to do when the packet ends.

A SETUP token aimed at the current device address arms the block to accept the next packet as an 8-byte DATA0 configuration payload. When that payload arrives intact, the block loads a new 7-bit address from it and answers with an ACK handshake byte. An IN token aimed at the current address makes the block stream a DATA0 packet from a fixed 8-byte payload. The packet ends with two CRC16 bytes taken from an external transmit CRC generator. All other traffic is dropped. Output uses a valid/ready byte handshake with a last-byte marker.

States and transitions. `S_IDLE` goes to `S_RX_TOK` when a start byte arrives. `S_RX_TOK` goes, at the end marker, to `S_WAIT_DATA` (accepted SETUP), to `S_TX_DATA` (accepted IN) or back to `S_IDLE`. `S_WAIT_DATA` goes to `S_RX_DATA` on the next start byte. `S_RX_DATA` goes, at the end marker, to `S_TX_ACK` (good payload) or to `S_IDLE`. `S_TX_ACK` goes to `S_IDLE` once its byte is accepted. `S_TX_DATA` goes to `S_IDLE` once the last byte is accepted. A one-byte packet seen in `S_IDLE` or `S_WAIT_DATA` returns to or stays in `S_IDLE`.

Top module: `usb_txn_seq`

## Requirements
- R1: A synchronous active-high reset clears the device address to 0 and returns the FSM to idle. No byte is offered on the transmit port after reset.
- R2: A SETUP token (PID 0x2D) to the current address, followed by a DATA0 packet (PID 0xC3) of 11 bytes in total (PID, 8 payload bytes, 2 CRC bytes) with a good CRC, produces exactly one transmitted byte: ACK 0xD2, with the last marker set.
- R3: After R2, the device address becomes the low 7 bits of payload byte index 2 (packet byte 3). IN tokens to the new address are then answered, and IN tokens to the old address are not.
- R4: An IN token (PID 0x69) whose address field matches produces 11 bytes: 0xC3, the 8 payload bytes in order with byte 0 taken from PAYLOAD[7:0], the CRC16 low byte, then the CRC16 high byte. The last marker is set only on the final byte. The token address is the low 7 bits of packet byte 1, and a token is 3 bytes long.
- R5: An IN token whose address does not match produces no output.
- R6: A token with a failed CRC, or with a PID whose upper nibble is not the complement of its lower nibble, is ignored.
- R7: If the packet after an accepted SETUP has the wrong length or a failed CRC, no ACK is sent and the address stays unchanged.
- R8: Packets with any other PID (for example OUT 0xE1) produce no output.
- R9: While a transmit byte is offered and not accepted, the byte and its valid signal hold steady.
- R10: Once configured, a SETUP to the default address 0 is ignored, and the data packet that follows it gets no ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received packet byte |
| rx_sop | input | 1 | First byte of a packet |
| rx_eop | input | 1 | Last byte of a packet |
| rx_crc_ok | input | 1 | CRC verdict for the packet, valid with rx_eop |
| tx_crc16 | input | 16 | CRC16 of the outgoing payload from the transmit CRC generator |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_byte | output | 8 | Transmit byte |
| tx_last | output | 1 | Offered byte ends the packet |

## Verification
A corrupted address register is not visible until the next token ends. At that point an IN to the right address gets no answer, or an IN to a wrong address gets a full DATA0 packet within one cycle of the token's end marker. A wrong state or byte index shows up as a byte out of order, a missing or misplaced last marker, or a packet of the wrong length. A scoreboard catches each of these on the first transmitted byte that differs. A length counter that is off by one turns every good configuration payload into a dropped one, so the expected ACK never appears.

// File: rtl/usb_txn_pkg.sv
package usb_txn_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RX_TOK,
        S_WAIT_DATA,
        S_RX_DATA,
        S_TX_ACK,
        S_TX_DATA
    } seq_state_t;

    localparam logic [7:0] PID_SETUP = 8'h2D;
    localparam logic [7:0] PID_IN    = 8'h69;
    localparam logic [7:0] PID_DATA0 = 8'hC3;
    localparam logic [7:0] PID_ACK   = 8'hD2;
endpackage

// File: rtl/usb_pid_check.sv
module usb_pid_check
    import usb_txn_pkg::*;
(
    input  logic [7:0] pid,
    output logic       is_setup,
    output logic       is_in,
    output logic       is_data0
);
    logic compl_ok;

    always_comb begin
        compl_ok = (pid[7:4] == ~pid[3:0]);
        is_setup = compl_ok && (pid[3:0] == PID_SETUP[3:0]);
        is_in    = compl_ok && (pid[3:0] == PID_IN[3:0]);
        is_data0 = compl_ok && (pid[3:0] == PID_DATA0[3:0]);
    end
endmodule

// File: rtl/usb_tx_mux.sv
module usb_tx_mux
    import usb_txn_pkg::*;
#(
    parameter int              PAYLOAD_BYTES = 8,
    parameter logic [8*PAYLOAD_BYTES-1:0] PAYLOAD = '0,
    parameter int              IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [15:0]      crc16,
    output logic [7:0]       byte_o,
    output logic             last_o
);
    localparam int LAST_IDX = PAYLOAD_BYTES + 2;

    logic [7:0] pay_arr [PAYLOAD_BYTES];

    for (genvar g = 0; g < PAYLOAD_BYTES; g++) begin : g_pay
        assign pay_arr[g] = PAYLOAD[8*g +: 8];
    end

    always_comb begin
        byte_o = PID_DATA0;
        last_o = (int'(idx) == LAST_IDX);
        if (int'(idx) == 0) begin
            byte_o = PID_DATA0;
        end else if (int'(idx) <= PAYLOAD_BYTES) begin
            byte_o = pay_arr[int'(idx) - 1];
        end else if (int'(idx) == PAYLOAD_BYTES + 1) begin
            byte_o = crc16[7:0];
        end else begin
            byte_o = crc16[15:8];
        end
    end
endmodule

// File: rtl/usb_txn_seq.sv
module usb_txn_seq
    import usb_txn_pkg::*;
#(
    parameter int ADDR_W        = 7,
    parameter int SETUP_LEN     = 8,
    parameter int ADDR_BYTE     = 2,
    parameter int PAYLOAD_BYTES = 8,
    parameter logic [8*PAYLOAD_BYTES-1:0] PAYLOAD = 64'h8877_6655_4433_2211
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_sop,
    input  logic        rx_eop,
    input  logic        rx_crc_ok,
    input  logic [15:0] tx_crc16,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        tx_last
);
    localparam int TOK_LAST_IDX  = 2;
    localparam int DATA_LAST_IDX = SETUP_LEN + 2;
    localparam int CAP_IDX       = ADDR_BYTE + 1;
    localparam int CNT_W         = $clog2(DATA_LAST_IDX + 2);
    localparam int TX_LAST_IDX   = PAYLOAD_BYTES + 2;
    localparam int IDX_W         = $clog2(TX_LAST_IDX + 1);

    seq_state_t          state, nxt;
    logic [7:0]          pid_q;
    logic [7:0]          cap_byte;
    logic [CNT_W-1:0]    rx_cnt;
    logic [ADDR_W-1:0]   dev_addr;
    logic [IDX_W-1:0]    tx_idx;
    logic                is_setup, is_in, is_data0;
    logic                addr_hit, tok_good, data_good;
    logic [7:0]          mux_byte;
    logic                mux_last;

    usb_pid_check u_pid (
        .pid      (pid_q),
        .is_setup (is_setup),
        .is_in    (is_in),
        .is_data0 (is_data0)
    );

    usb_tx_mux #(
        .PAYLOAD_BYTES (PAYLOAD_BYTES),
        .PAYLOAD       (PAYLOAD),
        .IDX_W         (IDX_W)
    ) u_mux (
        .idx    (tx_idx),
        .crc16  (tx_crc16),
        .byte_o (mux_byte),
        .last_o (mux_last)
    );

    always_comb begin
        addr_hit  = (cap_byte[ADDR_W-1:0] == dev_addr);
        tok_good  = rx_crc_ok && (int'(rx_cnt) == TOK_LAST_IDX) && addr_hit;
        data_good = rx_crc_ok && (int'(rx_cnt) == DATA_LAST_IDX) && is_data0;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:
                if (rx_valid && rx_sop && !rx_eop) nxt = S_RX_TOK;
            S_RX_TOK:
                if (rx_valid && rx_eop) begin
                    if (tok_good && is_setup)   nxt = S_WAIT_DATA;
                    else if (tok_good && is_in) nxt = S_TX_DATA;
                    else                        nxt = S_IDLE;
                end
            S_WAIT_DATA:
                if (rx_valid && rx_sop) nxt = rx_eop ? S_IDLE : S_RX_DATA;
            S_RX_DATA:
                if (rx_valid && rx_eop) nxt = data_good ? S_TX_ACK : S_IDLE;
            S_TX_ACK:
                if (tx_ready) nxt = S_IDLE;
            S_TX_DATA:
                if (tx_ready && mux_last) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Packet tracking, address register and transmit index
    always_ff @(posedge clk) begin
        if (rst) begin
            pid_q    <= '0;
            cap_byte <= '0;
            rx_cnt   <= '0;
            dev_addr <= '0;
            tx_idx   <= '0;
        end else begin
            if ((state == S_IDLE || state == S_WAIT_DATA) && rx_valid && rx_sop) begin
                pid_q  <= rx_byte;
                rx_cnt <= CNT_W'(1);
            end else if ((state == S_RX_TOK || state == S_RX_DATA) && rx_valid) begin
                if ((state == S_RX_TOK && int'(rx_cnt) == 1) ||
                    (state == S_RX_DATA && int'(rx_cnt) == CAP_IDX))
                    cap_byte <= rx_byte;
                if (rx_cnt != '1) rx_cnt <= rx_cnt + 1'b1;
            end
            if (state == S_RX_DATA && nxt == S_TX_ACK)
                dev_addr <= cap_byte[ADDR_W-1:0];
            if (state != S_TX_DATA)  tx_idx <= '0;
            else if (tx_ready)       tx_idx <= tx_idx + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_byte  = 8'h00;
        tx_last  = 1'b0;
        unique case (state)
            S_TX_ACK: begin
                tx_valid = 1'b1;
                tx_byte  = PID_ACK;
                tx_last  = 1'b1;
            end
            S_TX_DATA: begin
                tx_valid = 1'b1;
                tx_byte  = mux_byte;
                tx_last  = mux_last;
            end
            default: ;
        endcase
    end

    AST_RST_IDLE: assert property (@(posedge clk)
        rst |=> (state == S_IDLE && dev_addr == '0)); // R1

    AST_ADDR_ONLY_ACK: assert property (@(posedge clk) disable iff (rst)
        !$stable(dev_addr) |-> (state == S_TX_ACK)); // R3

    AST_PKT_END: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid); // R4

    AST_BAD_TOK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == S_RX_TOK && rx_valid && rx_eop && !rx_crc_ok) |=> !tx_valid); // R6

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R9
endmodule

// File: tb/usb_txn_seq_tb.sv
module usb_txn_seq_tb;
    localparam logic [63:0] PAY = 64'h8877_6655_4433_2211;
    localparam logic [15:0] CRC = 16'hBEEF;

    typedef logic [7:0] pkt_t [16];

    logic        clk = 0;
    logic        rst = 1;
    logic        rx_valid = 0, rx_sop = 0, rx_eop = 0, rx_crc_ok = 0;
    logic [7:0]  rx_byte = 0;
    logic        tx_ready = 1;
    logic        stall = 0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_byte;

    int          n_checks = 0, n_fails = 0, cycles = 0;
    string       cur_req = "R1";
    logic [8:0]  exp_q [$];
    logic        hold_pend = 0;
    logic [7:0]  hold_byte = 0;

    always #10 clk = ~clk;

    usb_txn_seq u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok),
        .tx_crc16(CRC), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_last(tx_last)
    );

    always @(posedge clk) tx_ready <= stall ? ~tx_ready : 1'b1;

    // Monitor: pops expected bytes as the design hands them over
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pend) begin
                n_checks++;
                if (!(tx_valid && tx_byte == hold_byte)) begin
                    n_fails++;
                    $display("FAIL R9: held byte v=%0b b=%h expected v=1 b=%h", tx_valid, tx_byte, hold_byte);
                end
            end
            hold_pend = tx_valid && !tx_ready;
            hold_byte = tx_byte;
            if (tx_valid && tx_ready) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fails++;
                    $display("FAIL %s: unexpected byte %h last=%0b expected none", cur_req, tx_byte, tx_last);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    if ({tx_last, tx_byte} != e) begin
                        n_fails++;
                        $display("FAIL %s: byte %h last=%0b expected %h last=%0b",
                                 cur_req, tx_byte, tx_last, e[7:0], e[8]);
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fails++;
            $display("FAIL watchdog: cycles %0d expected below 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    task automatic send_pkt(input pkt_t b, input int n, input bit crc);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid  = 1;
            rx_byte   = b[i];
            rx_sop    = (i == 0);
            rx_eop    = (i == n - 1);
            rx_crc_ok = crc;
        end
        @(negedge clk);
        rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_crc_ok = 0;
    endtask

    task automatic tok(input logic [7:0] pid, input logic [6:0] a, input bit crc);
        pkt_t b = '{default: 8'h00};
        b[0] = pid; b[1] = {1'b0, a}; b[2] = 8'h10;
        send_pkt(b, 3, crc);
    endtask

    task automatic dat(input int plen, input logic [7:0] b2, input bit crc);
        pkt_t b = '{default: 8'h00};
        b[0] = 8'hC3;
        for (int k = 0; k < plen; k++) b[k + 1] = (k == 2) ? b2 : 8'h40 + 8'(k);
        b[plen + 1] = 8'hAA; b[plen + 2] = 8'h55;
        send_pkt(b, plen + 3, crc);
    endtask

    task automatic push_data();
        exp_q.push_back({1'b0, 8'hC3});
        for (int k = 0; k < 8; k++) exp_q.push_back({1'b0, PAY[8*k +: 8]});
        exp_q.push_back({1'b0, CRC[7:0]});
        exp_q.push_back({1'b1, CRC[15:8]});
    endtask

    task automatic push_ack();
        exp_q.push_back({1'b1, 8'hD2});
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL %s: %0d bytes missing expected 0", cur_req, exp_q.size());
        end
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        n_checks++;
        if (tx_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: tx_valid=%b expected 0", tx_valid);
        end

        cur_req = "R4"; push_data(); tok(8'h69, 7'h00, 1); settle();
        cur_req = "R5"; tok(8'h69, 7'h05, 1); settle();
        cur_req = "R6"; tok(8'h2D, 7'h00, 0); dat(8, 8'h11, 1); settle();
        cur_req = "R6"; tok(8'h3D, 7'h00, 1); dat(8, 8'h11, 1); settle();
        cur_req = "R7"; tok(8'h2D, 7'h00, 1); dat(7, 8'h22, 1); settle();
        cur_req = "R7"; tok(8'h2D, 7'h00, 1); dat(8, 8'h22, 0); settle();
        cur_req = "R7"; push_data(); tok(8'h69, 7'h00, 1); settle();
        cur_req = "R2"; push_ack(); tok(8'h2D, 7'h00, 1); dat(8, 8'h9A, 1); settle();
        cur_req = "R3"; stall = 1; push_data(); tok(8'h69, 7'h1A, 1); settle();
        stall = 0;
        cur_req = "R3"; tok(8'h69, 7'h00, 1); settle();
        cur_req = "R8"; tok(8'hE1, 7'h1A, 1); settle();
        cur_req = "R10"; tok(8'h2D, 7'h00, 1); dat(8, 8'h05, 1); settle();
        cur_req = "R10"; push_data(); tok(8'h69, 7'h1A, 1); settle();
        cur_req = "R2"; push_ack(); tok(8'h2D, 7'h1A, 1); dat(8, 8'h33, 1); settle();
        cur_req = "R3"; push_data(); tok(8'h69, 7'h33, 1); settle();

        cur_req = "R1";
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        push_data(); tok(8'h69, 7'h00, 1); settle();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule